// File: doc/BRIEF.md
# Sticky Right Shifter for Significand Alignment

This block aligns a 128-bit significand by shifting it right by a 16-bit unsigned count. The operand arrives as two 64-bit words (upper and lower). Bits that fall off the bottom are never silently discarded: they are summarised so that later rounding logic still knows whether any nonzero value was lost.

Two modes are selected per transaction. In sticky mode the full 128-bit value is shifted and any nonzero lost bit forces bit 0 of the result to 1. In extra mode the upper word is treated as the integer part and the lower word as a fraction. The integer part is shifted right by the count and the fraction bits are returned in a separate 64-bit extra word. That word's top bit is the last integer bit shifted out, and its lower bits are nonzero only when earlier bits that were shifted out were nonzero. Every count from 128 up to the maximum 16-bit value takes the saturated path. The low count bits are never reused.

A transaction is accepted on a clock edge where `in_valid` is high. The result appears on registered outputs one cycle later, together with `out_valid`. The outputs hold their value while no new transaction arrives.

Top module: `jam_shifter`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_hi`, `out_lo` and `out_extra` keep their previous values. After reset, all outputs are zero.
- R2: In sticky mode (`in_mode` = 0) with count 0, {`out_hi`,`out_lo`} equals {`in_hi`,`in_lo`}.
- R3: In sticky mode with 0 < count < 128, {`out_hi`,`out_lo`} is the 128-bit operand logically shifted right by the count. Bit 0 of the result is also set when any bit shifted out was 1.
- R4: In sticky mode with count ≥ 128 (up to 65535), the result is 1 when the operand is nonzero and 0 otherwise. The counts are not reduced modulo any power of two.
- R5: In sticky mode, `out_extra` is zero.
- R6: In extra mode (`in_mode` = 1) with count 0, `out_lo` equals `in_hi` and `out_extra` equals `in_lo`.
- R7: In extra mode with 0 < count < 64, `out_lo` is `in_hi` shifted right by the count. `out_extra` is `in_hi` shifted left by (64 − count), with bit 0 also set when `in_lo` is nonzero. Bit 63 of `out_extra` therefore equals bit (count − 1) of `in_hi`.
- R8: In extra mode with count 64, `out_lo` is 0 and `out_extra` is `in_hi` with bit 0 also set when `in_lo` is nonzero.
- R9: In extra mode with count > 64 (up to 65535), `out_lo` is 0 and `out_extra` is 1 when either input word is nonzero and 0 otherwise.
- R10: In extra mode, `out_hi` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction accepted on this edge |
| in_mode | input | 1 | 0 = sticky mode, 1 = extra mode |
| in_hi | input | 64 | Upper operand word |
| in_lo | input | 64 | Lower operand word |
| in_cnt | input | 16 | Unsigned right-shift count |
| out_valid | output | 1 | Result registered from the previous accepted transaction |
| out_hi | output | 64 | Upper result word (zero in extra mode) |
| out_lo | output | 64 | Lower result word, or the integer part in extra mode |
| out_extra | output | 64 | Word summarising shifted-out bits in extra mode (zero in sticky mode) |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing, the holding of the outputs while idle, zero-count pass-through in sticky mode, the saturated sticky result for large counts, the zeroed words that each mode leaves unused, and the collapse of the extra word to a flag beyond 64. The exact shifted values and the sticky bit for intermediate counts are shown only by the bench. It sweeps every count from 0 through 130 plus large counts up to 65535, over fixed and random operands. The sticky results are compared against a double-width shift model, and the extra-word results against formulas derived from the requirements.

// File: rtl/jam_shifter_pkg.sv
package jam_shifter_pkg;
  typedef enum logic {
    SHR_STICKY = 1'b0,
    SHR_EXTRA  = 1'b1
  } shr_mode_e;
endpackage

// File: rtl/jam_sticky_path.sv
module jam_sticky_path #(
  parameter int W     = 64,
  parameter int CNT_W = 16
) (
  input  logic [2*W-1:0]   opnd,
  input  logic [CNT_W-1:0] cnt,
  output logic [2*W-1:0]   res
);
  localparam int OP_W = 2 * W;
  localparam int SH_W = $clog2(OP_W);

  logic            sat;
  logic [SH_W-1:0] amt;
  logic [OP_W-1:0] drop_mask;
  logic [OP_W-1:0] shifted;
  logic            lost;

  // Saturation is decided on the full count so no large count wraps.
  assign sat = (cnt >= CNT_W'(OP_W));
  assign amt = cnt[SH_W-1:0];

  always_comb begin
    drop_mask = ~({OP_W{1'b1}} << amt);
    if (sat) begin
      shifted = '0;
      lost    = |opnd;
    end else begin
      shifted = opnd >> amt;
      lost    = |(opnd & drop_mask);
    end
    res = shifted | {{(OP_W-1){1'b0}}, lost};
  end
endmodule

// File: rtl/jam_extra_path.sv
module jam_extra_path #(
  parameter int W     = 64,
  parameter int CNT_W = 16
) (
  input  logic [W-1:0]     hi,
  input  logic [W-1:0]     lo,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     int_part,
  output logic [W-1:0]     extra
);
  localparam int LW = $clog2(W);

  logic [LW-1:0] amt;
  logic [LW-1:0] back;
  logic          lo_nz;
  logic          any_nz;
  logic          is_zero;
  logic          below_w;
  logic          at_w;

  assign amt     = cnt[LW-1:0];
  assign back    = LW'(0) - amt;       // W - amt for amt in 1..W-1
  assign lo_nz   = |lo;
  assign any_nz  = (|hi) | lo_nz;
  assign is_zero = (cnt == '0);
  assign below_w = (cnt < CNT_W'(W));
  assign at_w    = (cnt == CNT_W'(W));

  always_comb begin
    if (is_zero) begin
      int_part = hi;
      extra    = lo;
    end else if (below_w) begin
      int_part = hi >> amt;
      extra    = (hi << back) | {{(W-1){1'b0}}, lo_nz};
    end else if (at_w) begin
      int_part = '0;
      extra    = hi | {{(W-1){1'b0}}, lo_nz};
    end else begin
      int_part = '0;
      extra    = {{(W-1){1'b0}}, any_nz};
    end
  end
endmodule

// File: rtl/jam_shifter.sv
module jam_shifter
  import jam_shifter_pkg::*;
#(
  parameter int W     = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic [W-1:0]     in_hi,
  input  logic [W-1:0]     in_lo,
  input  logic [CNT_W-1:0] in_cnt,
  output logic             out_valid,
  output logic [W-1:0]     out_hi,
  output logic [W-1:0]     out_lo,
  output logic [W-1:0]     out_extra
);
  localparam int OP_W = 2 * W;

  logic [OP_W-1:0] stk_res;
  logic [W-1:0]    ext_int;
  logic [W-1:0]    ext_word;

  logic            vld_d, vld_q;
  logic [W-1:0]    hi_d, hi_q;
  logic [W-1:0]    lo_d, lo_q;
  logic [W-1:0]    ex_d, ex_q;

  jam_sticky_path #(.W(W), .CNT_W(CNT_W)) u_sticky (
    .opnd (({in_hi, in_lo})),
    .cnt  (in_cnt),
    .res  (stk_res)
  );

  jam_extra_path #(.W(W), .CNT_W(CNT_W)) u_extra (
    .hi       (in_hi),
    .lo       (in_lo),
    .cnt      (in_cnt),
    .int_part (ext_int),
    .extra    (ext_word)
  );

  // Next state: load only when a transaction is accepted.
  always_comb begin
    vld_d = in_valid;
    hi_d  = hi_q;
    lo_d  = lo_q;
    ex_d  = ex_q;
    if (in_valid) begin
      if (shr_mode_e'(in_mode) == SHR_EXTRA) begin
        hi_d = '0;
        lo_d = ext_int;
        ex_d = ext_word;
      end else begin
        hi_d = stk_res[OP_W-1:W];
        lo_d = stk_res[W-1:0];
        ex_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
      ex_q  <= '0;
    end else begin
      vld_q <= vld_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      ex_q  <= ex_d;
    end
  end

  assign out_valid = vld_q;
  assign out_hi    = hi_q;
  assign out_lo    = lo_q;
  assign out_extra = ex_q;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_hi) && $stable(out_lo) && $stable(out_extra)));
  assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == SHR_STICKY && in_cnt == '0)
    |=> (out_hi == $past(in_hi) && out_lo == $past(in_lo)));
  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == SHR_STICKY && in_cnt >= CNT_W'(OP_W))
    |=> (out_hi == '0 && out_lo[W-1:1] == '0 &&
         out_lo[0] == (($past(in_hi) != '0) || ($past(in_lo) != '0))));
  assert_no_extra_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == SHR_STICKY) |=> (out_extra == '0));
  assert_collapse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == SHR_EXTRA && in_cnt > CNT_W'(W))
    |=> (out_lo == '0 && out_extra[W-1:1] == '0));
  assert_narrow_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == SHR_EXTRA) |=> (out_hi == '0));
endmodule

// File: tb/jam_shifter_tb.sv
module jam_shifter_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_mode;
  logic [63:0] in_hi;
  logic [63:0] in_lo;
  logic [15:0] in_cnt;
  logic        out_valid;
  logic [63:0] out_hi;
  logic [63:0] out_lo;
  logic [63:0] out_extra;

  int n_chk;
  int n_bad;

  jam_shifter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_hi     (in_hi),
    .in_lo     (in_lo),
    .in_cnt    (in_cnt),
    .out_valid (out_valid),
    .out_hi    (out_hi),
    .out_lo    (out_lo),
    .out_extra (out_extra)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cnt=%0d mode=%0d act=%h exp=%h", tag, in_cnt, in_mode, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_sticky(logic [63:0] h, logic [63:0] l, int c);
    logic [255:0] v;
    int ce;
    ce = (c > 128) ? 128 : c;
    v = {h, l, 128'd0} >> ce;
    return v[255:128] | {127'd0, (v[127:0] != '0)};
  endfunction

  function automatic logic [127:0] ref_extra(logic [63:0] h, logic [63:0] l, int c);
    logic lnz;
    lnz = (l != '0);
    if (c == 0)       return {h, l};
    else if (c < 64)  return {h >> c, (h << (64 - c)) | {63'd0, lnz}};
    else if (c == 64) return {64'd0, h | {63'd0, lnz}};
    else              return {64'd0, 63'd0, ((h | l) != '0)};
  endfunction

  task automatic run_one(input logic m, input logic [63:0] h, input logic [63:0] l,
                         input int c, input bit do_hold);
    logic [127:0] e;
    logic [191:0] snap;
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = m;
    in_hi    = h;
    in_lo    = l;
    in_cnt   = 16'(c);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 valid", {191'd0, out_valid}, {191'd0, 1'b1});
    if (m == 1'b0) begin
      e = ref_sticky(h, l, c);
      if (c == 0)       chk("R2 sticky pass", {out_hi, out_lo, 64'd0}, {e, 64'd0});
      else if (c < 128) chk("R3 sticky shift", {out_hi, out_lo, 64'd0}, {e, 64'd0});
      else              chk("R4 sticky sat", {out_hi, out_lo, 64'd0}, {e, 64'd0});
      chk("R5 no extra", {128'd0, out_extra}, 192'd0);
    end else begin
      e = ref_extra(h, l, c);
      if (c == 0)      chk("R6 extra pass", {out_lo, out_extra, 64'd0}, {e, 64'd0});
      else if (c < 64) chk("R7 extra shift", {out_lo, out_extra, 64'd0}, {e, 64'd0});
      else if (c == 64) chk("R8 extra at64", {out_lo, out_extra, 64'd0}, {e, 64'd0});
      else             chk("R9 extra collapse", {out_lo, out_extra, 64'd0}, {e, 64'd0});
      if (c >= 1 && c <= 64)
        chk("R7 last bit", {191'd0, out_extra[63]}, {191'd0, h[c-1]});
      chk("R10 int narrow", {128'd0, out_hi}, 192'd0);
    end
    if (do_hold) begin
      snap = {out_hi, out_lo, out_extra};
      in_hi  = ~h;
      in_lo  = ~l;
      in_cnt = 16'd1;
      @(negedge clk);
      chk("R1 hold", {out_hi, out_lo, out_extra}, snap);
      chk("R1 idle valid", {191'd0, out_valid}, 192'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int big_cnt [6];
    logic [63:0] h, l;
    n_chk = 0;
    n_bad = 0;
    big_cnt = '{191, 192, 255, 256, 32767, 65535};
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_mode  = 1'b0;
    in_hi    = '0;
    in_lo    = '0;
    in_cnt   = '0;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {out_hi, out_lo, out_extra}, 192'd0);
    chk("R1 reset valid", {191'd0, out_valid}, 192'd0);
    for (int ci = 0; ci < 137; ci++) begin
      int c;
      c = (ci < 131) ? ci : big_cnt[ci-131];
      for (int p = 0; p < 8; p++) begin
        case (p)
          0: begin h = '0; l = '0; end
          1: begin h = '1; l = '1; end
          2: begin h = '0; l = 64'd1; end
          3: begin h = 64'h8000_0000_0000_0000; l = '0; end
          4: begin h = '0; l = 64'h8000_0000_0000_0000; end
          default: begin h = {$urandom, $urandom}; l = {$urandom, $urandom}; end
        endcase
        for (int m = 0; m < 2; m++) run_one(m[0], h, l, c, (p == 5));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule